// File: doc/BRIEF.md
# System configuration register file

This block is a bank of eleven 32-bit configuration words placed at fixed offsets inside a 1 KB address window. It sits on a simple register bus with an access strobe, a write enable, a word address, write data and read data. Each word has its own update rule. Some bits are plain storage behind a writable mask. Some can only be cleared by software. Some are sticky bits that software can only set. One flag is raised by hardware and cleared when software writes a one to it.

Reads are combinational from the address. A write lands on the clock edge that samples the strobe. The four line-select words feed the interrupt routing logic through a flat output bus. Any access to an offset with no register, including a misaligned address, returns zero, changes nothing, and raises an error output for that cycle.

Top module: `sys_cfg_regs`

## Requirements
- R1: While reset is asserted and after it is released, offset 0x04 (config A) reads 0x7C000001 and every other mapped offset reads 0x00000000.
- R2: Offset 0x00 (remap) stores the written data ANDed with 0x00000107. Offset 0x24 (key) stores only data bits [7:0]. The four line-select words at 0x08, 0x0C, 0x10 and 0x14 store only data bits [15:0]. Each of these reads back exactly what it stored.
- R3: A write to 0x04 stores data AND 0xFCFF0100 in the upper bits. Bit 0 becomes old bit 0 AND written bit 0, so software can clear it but can never set it.
- R4: At offset 0x1C (config B), bits [3:0] are lock bits. A write ORs data bits [3:0] into them, and only reset clears them.
- R5: Config B bit 8 is a fault flag. A one-cycle pulse on fault_set_i sets it. A write to 0x1C with data bit 8 = 1 clears it, and a write with bit 8 = 0 leaves it unchanged. If a set and a clear arrive in the same cycle, the set wins.
- R6: The protect words at 0x20 and 0x28 OR in every written value. Their bits stay set until reset.
- R7: Writes to the SRAM control word at 0x18 are ignored, and that offset always reads zero with no error.
- R8: An access to any other offset in the window, or to an address with bit 1 or bit 0 set, reads zero and leaves all state unchanged. err_o is high in the same cycle as that access. err_o is low for accesses to mapped offsets.
- R9: sel_o carries line-select word k (offset 0x08 + 4k) in bits [16k+15:16k] for k = 0..3.
- R10: A write takes effect at the clock edge that samples it. In the cycle of the write, the read data still shows the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 10 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| err_o | output | 1 | Access to an unmapped or misaligned offset |
| fault_set_i | input | 1 | Hardware set pulse for the config B fault flag |
| sel_o | output | 64 | Four 16-bit line-select words |

## Verification
The assertions assume that bus_addr, bus_we and bus_wdata are stable for the whole cycle in which bus_en is high. They also assume that fault_set_i is a clean level sampled at the clock edge. The property that an unmapped write leaves state untouched holds only when no fault pulse arrives in the same cycle, and it is guarded for that case. The bench drives every input one time unit after the rising edge and holds it for exactly one cycle. It returns the strobe low between operations where needed, and it raises fault_set_i together with a bus write only in the one case that tests set-over-clear priority.

// File: rtl/sys_cfg_pkg.sv
package sys_cfg_pkg;

    localparam int DATA_W   = 32;
    localparam int SEL_W    = 16;
    localparam int NUM_SEL  = 4;
    localparam int NUM_REGS = 11;

    // word index of each register (byte offset / 4)
    localparam int IDX_REMAP = 0;
    localparam int IDX_CFGA  = 1;
    localparam int IDX_SEL0  = 2;
    localparam int IDX_SRAM  = 6;
    localparam int IDX_CFGB  = 7;
    localparam int IDX_PROT1 = 8;
    localparam int IDX_KEY   = 9;
    localparam int IDX_PROT2 = 10;

    localparam logic [DATA_W-1:0] REMAP_KEEP = 32'h0000_0107;
    localparam logic [DATA_W-1:0] CFGA_KEEP  = 32'hFCFF_0100;
    localparam logic [DATA_W-1:0] CFGA_RST   = 32'h7C00_0001;
    localparam int                KEY_W      = 8;
    localparam int                LOCK_W     = 4;
    localparam int                FLAG_BIT   = 8;

    typedef struct packed {
        logic [DATA_W-1:0]                remap;
        logic [DATA_W-1:0]                cfga;
        logic [NUM_SEL-1:0][SEL_W-1:0]    sel;
        logic [LOCK_W-1:0]                lock;
        logic                             flag;
        logic [DATA_W-1:0]                prot1;
        logic [KEY_W-1:0]                 key;
        logic [DATA_W-1:0]                prot2;
    } regs_t;

    localparam regs_t REGS_RST = '{
        remap: '0, cfga: CFGA_RST, sel: '0, lock: '0,
        flag: 1'b0, prot1: '0, key: '0, prot2: '0
    };

endpackage

// File: rtl/sys_cfg_decode.sv
module sys_cfg_decode #(
    parameter int ADDR_W   = 10,
    parameter int NUM_REGS = 11
) (
    input  logic                bus_en,
    input  logic [ADDR_W-1:0]   bus_addr,
    output logic [NUM_REGS-1:0] hit_o,
    output logic                err_o
);
    localparam int WORD_W = ADDR_W - 2;

    logic              aligned;
    logic [WORD_W-1:0] word;

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign word    = bus_addr[ADDR_W-1:2];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
        assign hit_o[i] = aligned && (word == WORD_W'(i));
    end

    assign err_o = bus_en && !(|hit_o);
endmodule

// File: rtl/sys_cfg_rdmux.sv
module sys_cfg_rdmux #(
    parameter int NUM_REGS = 11,
    parameter int DATA_W   = 32
) (
    input  logic [NUM_REGS-1:0]             hit_i,
    input  logic [NUM_REGS-1:0][DATA_W-1:0] words_i,
    output logic [DATA_W-1:0]               rdata_o
);
    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            rdata_o = rdata_o | (words_i[i] & {DATA_W{hit_i[i]}});
        end
    end
endmodule

// File: rtl/sys_cfg_regs.sv
module sys_cfg_regs
    import sys_cfg_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_en,
    input  logic                       bus_we,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    output logic                       err_o,
    input  logic                       fault_set_i,
    output logic [NUM_SEL*SEL_W-1:0]   sel_o
);
    regs_t st_d, st_q;

    logic [NUM_REGS-1:0]             hit;
    logic [NUM_REGS-1:0][DATA_W-1:0] words;
    logic                            wr;

    sys_cfg_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec (
        .bus_en   (bus_en),
        .bus_addr (bus_addr),
        .hit_o    (hit),
        .err_o    (err_o)
    );

    assign wr = bus_en && bus_we;

    always_comb begin
        st_d = st_q;
        if (wr && hit[IDX_REMAP]) begin
            st_d.remap = bus_wdata & REMAP_KEEP;
        end
        if (wr && hit[IDX_CFGA]) begin
            st_d.cfga    = bus_wdata & CFGA_KEEP;
            st_d.cfga[0] = st_q.cfga[0] & bus_wdata[0];
        end
        for (int k = 0; k < NUM_SEL; k++) begin
            if (wr && hit[IDX_SEL0+k]) begin
                st_d.sel[k] = bus_wdata[SEL_W-1:0];
            end
        end
        if (wr && hit[IDX_CFGB]) begin
            st_d.lock = st_q.lock | bus_wdata[LOCK_W-1:0];
            if (bus_wdata[FLAG_BIT]) begin
                st_d.flag = 1'b0;
            end
        end
        if (fault_set_i) begin
            st_d.flag = 1'b1;
        end
        if (wr && hit[IDX_PROT1]) begin
            st_d.prot1 = st_q.prot1 | bus_wdata;
        end
        if (wr && hit[IDX_KEY]) begin
            st_d.key = bus_wdata[KEY_W-1:0];
        end
        if (wr && hit[IDX_PROT2]) begin
            st_d.prot2 = st_q.prot2 | bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= REGS_RST;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        words            = '0;
        words[IDX_REMAP] = st_q.remap;
        words[IDX_CFGA]  = st_q.cfga;
        for (int k = 0; k < NUM_SEL; k++) begin
            words[IDX_SEL0+k] = DATA_W'(st_q.sel[k]);
        end
        words[IDX_SRAM]  = '0;
        words[IDX_CFGB]  = DATA_W'({st_q.flag, {(FLAG_BIT-LOCK_W){1'b0}}, st_q.lock});
        words[IDX_PROT1] = st_q.prot1;
        words[IDX_KEY]   = DATA_W'(st_q.key);
        words[IDX_PROT2] = st_q.prot2;
    end

    sys_cfg_rdmux #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rd (
        .hit_i   (hit),
        .words_i (words),
        .rdata_o (bus_rdata)
    );

    assign sel_o = st_q.sel;
endmodule

// File: rtl/sys_cfg_chk.sv
module sys_cfg_chk
    import sys_cfg_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              err_o,
    input  logic              fault_set_i,
    input  regs_t             st_q
);
    localparam logic [ADDR_W-1:0] SRAM_OFF = ADDR_W'(IDX_SRAM * 4);

    // R3: the bit that software may only clear never comes back once low
    assert_fw_clear_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.cfga[0] |=> !st_q.cfga[0]);

    // R4: lock bits only accumulate
    assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.lock & $past(st_q.lock)) == $past(st_q.lock)));

    // R5: a hardware pulse always leaves the flag set
    assert_flag_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fault_set_i |=> st_q.flag);

    // R6: protect bits only accumulate
    assert_prot_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((st_q.prot1 & $past(st_q.prot1)) == $past(st_q.prot1)) &&
                  ((st_q.prot2 & $past(st_q.prot2)) == $past(st_q.prot2))));

    // R7: SRAM control word reads zero and never errors
    assert_sram_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == SRAM_OFF) |-> (bus_rdata == '0 && !err_o));

    // R8: error access reads zero
    assert_unmapped_rd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (bus_rdata == '0));

    // R8: error write leaves state untouched
    assert_unmapped_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && err_o && !fault_set_i) |=> $stable(st_q));
endmodule

bind sys_cfg_regs sys_cfg_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_en      (bus_en),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_rdata   (bus_rdata),
    .err_o       (err_o),
    .fault_set_i (fault_set_i),
    .st_q        (st_q)
);

// File: tb/tb_sys_cfg_regs.sv
`timescale 1ns/1ps
module tb_sys_cfg_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        err_o;
    logic        fault_set_i = 1'b0;
    logic [63:0] sel_o;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    typedef struct {
        int          kind;     // 0 read data + err, 1 err only, 2 line-select bus
        logic [31:0] exp;
        logic [63:0] exp_sel;
        bit          exp_err;
        string       tag;
    } item_t;

    item_t sb[$];

    always #2.5 clk = ~clk;

    sys_cfg_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .err_o(err_o), .fault_set_i(fault_set_i), .sel_o(sel_o)
    );

    task automatic push(input int kind, input logic [31:0] e, input logic [63:0] es,
                        input bit ee, input string t);
        item_t it;
        it.kind = kind; it.exp = e; it.exp_sel = es; it.exp_err = ee; it.tag = t;
        sb.push_back(it);
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic rd(input logic [9:0] a, input logic [31:0] e, input bit ee, input string t);
        step();
        bus_en = 1; bus_we = 0; bus_addr = a; fault_set_i = 0;
        push(0, e, '0, ee, t);
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d, input bit ee, input string t);
        step();
        bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d; fault_set_i = 0;
        push(1, '0, '0, ee, t);
    endtask

    task automatic wr_old(input logic [9:0] a, input logic [31:0] d, input logic [31:0] old,
                          input string t);
        step();
        bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d; fault_set_i = 0;
        push(0, old, '0, 1'b0, t);
    endtask

    task automatic wr_fault(input logic [9:0] a, input logic [31:0] d);
        step();
        bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d; fault_set_i = 1;
    endtask

    task automatic fault_pulse();
        step();
        bus_en = 0; bus_we = 0; fault_set_i = 1;
    endtask

    task automatic chk_sel(input logic [63:0] e, input string t);
        step();
        bus_en = 0; bus_we = 0; fault_set_i = 0;
        push(2, '0, e, 1'b0, t);
    endtask

    task automatic idle();
        step();
        bus_en = 0; bus_we = 0; fault_set_i = 0;
    endtask

    // monitor: compares mid-cycle, away from the rising edge
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                n_run++;
                if (it.kind == 2) begin
                    if (sel_o !== it.exp_sel) begin
                        n_fail++;
                        $display("FAIL %s: sel_o=%h expected %h", it.tag, sel_o, it.exp_sel);
                    end
                end else begin
                    if (err_o !== it.exp_err ||
                        (it.kind == 0 && bus_rdata !== it.exp)) begin
                        n_fail++;
                        $display("FAIL %s: rdata=%h err=%b expected rdata=%h err=%b",
                                 it.tag, bus_rdata, err_o, it.exp, it.exp_err);
                    end
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: cycles=%0d expected completion", cyc);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1 reset values
        rd(10'h004, 32'h7C00_0001, 0, "R1 config A");
        rd(10'h000, 32'h0, 0, "R1 remap");
        rd(10'h01C, 32'h0, 0, "R1 config B");
        rd(10'h028, 32'h0, 0, "R1 protect 2");
        chk_sel(64'h0, "R1 line selects");

        // R2 masked storage
        wr(10'h000, 32'hFFFF_FFFF, 0, "R2 remap wr");
        rd(10'h000, 32'h0000_0107, 0, "R2 remap mask");
        wr(10'h024, 32'hABCD_1234, 0, "R2 key wr");
        rd(10'h024, 32'h0000_0034, 0, "R2 key mask");
        wr(10'h008, 32'hDEAD_BEEF, 0, "R2 sel0 wr");
        rd(10'h008, 32'h0000_BEEF, 0, "R2 sel0 mask");
        wr(10'h014, 32'h1234_5678, 0, "R2 sel3 wr");
        rd(10'h014, 32'h0000_5678, 0, "R2 sel3 mask");

        // R9 export
        chk_sel(64'h5678_0000_0000_BEEF, "R9 partial");
        wr(10'h00C, 32'h0000_1111, 0, "R9 sel1 wr");
        wr(10'h010, 32'h0000_2222, 0, "R9 sel2 wr");
        chk_sel(64'h5678_2222_1111_BEEF, "R9 all four");

        // R3 clear-only bit 0
        wr(10'h004, 32'hFFFF_FFFF, 0, "R3 wr ones");
        rd(10'h004, 32'hFCFF_0101, 0, "R3 mask keeps bit0");
        wr(10'h004, 32'h0, 0, "R3 wr zero");
        rd(10'h004, 32'h0, 0, "R3 cleared");
        wr(10'h004, 32'h7C00_0001, 0, "R3 try set");
        rd(10'h004, 32'h7C00_0000, 0, "R3 bit0 not settable");

        // R4 sticky locks
        wr(10'h01C, 32'h5, 0, "R4 wr 5");
        rd(10'h01C, 32'h5, 0, "R4 after 5");
        wr(10'h01C, 32'h2, 0, "R4 wr 2");
        wr(10'h01C, 32'h0, 0, "R4 wr 0");
        rd(10'h01C, 32'h7, 0, "R4 accumulated");

        // R5 fault flag
        fault_pulse();
        rd(10'h01C, 32'h107, 0, "R5 flag set");
        wr(10'h01C, 32'h0, 0, "R5 wr 0");
        rd(10'h01C, 32'h107, 0, "R5 zero keeps flag");
        wr(10'h01C, 32'h100, 0, "R5 w1c");
        rd(10'h01C, 32'h007, 0, "R5 flag cleared");
        wr_fault(10'h01C, 32'h100);
        rd(10'h01C, 32'h107, 0, "R5 set beats clear");

        // R6 protect words
        wr(10'h020, 32'h0000_00F0, 0, "R6 p1 a");
        wr(10'h020, 32'h0000_000F, 0, "R6 p1 b");
        wr(10'h020, 32'h0, 0, "R6 p1 zero");
        rd(10'h020, 32'h0000_00FF, 0, "R6 p1 sticky");
        wr(10'h028, 32'h8000_0001, 0, "R6 p2 a");
        wr(10'h028, 32'h0000_0002, 0, "R6 p2 b");
        rd(10'h028, 32'h8000_0003, 0, "R6 p2 sticky");

        // R7 SRAM control word
        wr(10'h018, 32'hFFFF_FFFF, 0, "R7 wr ignored");
        rd(10'h018, 32'h0, 0, "R7 reads zero");

        // R8 unmapped and misaligned
        rd(10'h02C, 32'h0, 1, "R8 rd unmapped");
        wr(10'h3FC, 32'hFFFF_FFFF, 1, "R8 wr unmapped");
        wr(10'h001, 32'h0, 1, "R8 wr misaligned");
        rd(10'h000, 32'h0000_0107, 0, "R8 remap untouched");
        rd(10'h006, 32'h0, 1, "R8 rd misaligned");
        rd(10'h004, 32'h7C00_0000, 0, "R8 config A untouched");
        rd(10'h024, 32'h0000_0034, 0, "R8 key untouched");
        chk_sel(64'h5678_2222_1111_BEEF, "R8 selects untouched");

        // R10 write timing
        wr_old(10'h024, 32'h0000_0055, 32'h0000_0034, "R10 old value in write cycle");
        rd(10'h024, 32'h0000_0055, 0, "R10 new value next cycle");

        idle();
        idle();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule